// File: doc/BRIEF.md
# Trigger Input Conditioner

This block sits between a wide bank of trigger inputs and the trigger-type classifier. By default it takes 75 single-cycle trigger pulses, one per input line. These are 30 lines from the backplane trigger processors, 30 external front-panel lines and 15 further front-panel lines, packed into one vector. Each line passes through its own gate (an enable bit) and its own divider (a programmable prescale). The gated and divided pulse is forwarded on a matching output bit. The block also keeps two saturating counters per line: one counts every pulse seen and one counts every pulse forwarded.

A small synchronous register bus configures the block and reads it back. Software uses the bus to set the enable masks and the prescale values, to clear all counters at once, and to read any counter. Writing one command address injects a software trigger, which appears as a one-cycle pulse on a dedicated output next to the hardware triggers. Everything runs in one clock domain, intended for 250 MHz.

The bus read path is a two-state machine:
- `BUS_IDLE`: the machine waits here. A read request in `BUS_IDLE` captures the addressed word and takes the `IDLE_TO_RESP` transition.
- `BUS_RESP`: the captured word is presented with `bus_rvalid` high for exactly one cycle. The machine then always returns to `BUS_IDLE` through `RESP_TO_IDLE`.

Writes take effect in any state.

Top module: `trig_input_cond`

Address map (10-bit address, upper two bits select a bank, lower eight an index):
- Bank 0, index w (w < ceil(N_IN/32)): enable word. Bit b of word w enables input 32·w+b.
- Bank 0, index 0x40: software trigger command. Any write fires it.
- Bank 0, index 0x41: scaler clear. Any write clears all scalers.
- Bank 1, index i: prescale of input i, held in the low PS_W bits.
- Bank 2, index i: raw scaler of input i.
- Bank 3, index i: accepted scaler of input i.

## Requirements
- R1: After reset all trigger outputs, `sw_trig_o` and `bus_rvalid` are low. All enable bits, prescale values and scalers are zero.
- R2: A line whose enable bit is 0 never raises its output bit. The enable bit for input i is bit i%32 of the bank-0 word at index i/32.
- R3: An enabled input with prescale 0 raises its output bit for exactly one cycle, the cycle after the clock edge that samples the input pulse. Inputs pulsing together are forwarded together and independently.
- R4: With prescale N (bank 1, index i), only the (N+1)-th, 2(N+1)-th, … enabled pulse is forwarded. Pulses arriving while the line is disabled do not advance the count.
- R5: The raw scaler (bank 2) counts every input pulse whether or not the line is enabled. The accepted scaler (bank 3) counts forwarded pulses. Both are read zero-extended to 32 bits.
- R6: Both scalers saturate at all ones (SCW bits wide, 32 by default) and stay there until cleared.
- R7: A write to bank 0 index 0x41 zeroes every scaler. An input pulse in the same cycle is not counted but is still forwarded.
- R8: Writing a prescale value restarts that line's divide count, even when the value written is unchanged.
- R9: A write to bank 0 index 0x40 raises `sw_trig_o` for exactly the cycle after the write edge. Reads of that address do not fire it.
- R10: A read request in `BUS_IDLE` gives `bus_rvalid` high with the data in the next cycle, for one cycle. A read request made while in `BUS_RESP` is ignored. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, 250 MHz target |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | N_IN | One single-cycle pulse bit per trigger line |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 10 | Register address (bank, index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| trig_o | output | N_IN | Conditioned trigger pulses |
| sw_trig_o | output | 1 | Software-commanded trigger pulse |

## Verification
The scaler clear strobe and an input pulse can land on the same clock edge. The clear must win for the counters, while the pulse still reaches the output. The bench drives the clear write and a pulse on an enabled line on the same falling edge. It then checks that the output bit rises in the next cycle and that the raw scalers read back as zero. The saturation path is provoked with a narrowed counter width and a long unbroken pulse train, and must be released only by the same clear.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [1:0] BANK_CTRL = 2'd0;
    localparam logic [1:0] BANK_PS   = 2'd1;
    localparam logic [1:0] BANK_RAW  = 2'd2;
    localparam logic [1:0] BANK_ACC  = 2'd3;

    localparam logic [7:0] IDX_SW  = 8'h40;
    localparam logic [7:0] IDX_CLR = 8'h41;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_t;
endpackage

// File: rtl/tic_chan.sv
module tic_chan #(
    parameter int PS_W = 8,
    parameter int SCW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pulse,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    input  logic            ps_wr,
    input  logic            clr,
    output logic            acc_o,
    output logic [SCW-1:0]  raw_cnt,
    output logic [SCW-1:0]  acc_cnt
);
    logic [PS_W-1:0] div_q;
    logic            hit;
    logic            pass;

    assign hit  = pulse && en;
    assign pass = hit && (div_q == ps);

    // divider and forwarded pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            acc_o <= 1'b0;
        end else begin
            acc_o <= pass;
            if (ps_wr) begin
                div_q <= '0;
            end else if (hit) begin
                div_q <= (div_q == ps) ? '0 : div_q + 1'b1;
            end
        end
    end

    // saturating scalers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_cnt <= '0;
            acc_cnt <= '0;
        end else if (clr) begin
            raw_cnt <= '0;
            acc_cnt <= '0;
        end else begin
            if (pulse && (raw_cnt != '1)) raw_cnt <= raw_cnt + 1'b1;
            if (pass && (acc_cnt != '1))  acc_cnt <= acc_cnt + 1'b1;
        end
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> ($past(pulse) && $past(en)));                          // R2
    AST_ACC_NOT_ABOVE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt <= raw_cnt);                                             // R5
    AST_RAW_HOLDS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_cnt == '1 && !clr) |=> (raw_cnt == '1));                    // R6
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (raw_cnt == '0 && acc_cnt == '0));                       // R7
endmodule

// File: rtl/tic_regs.sv
module tic_regs
    import tic_pkg::*;
#(
    parameter int N_IN = 75,
    parameter int PS_W = 8,
    parameter int SCW  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [N_IN-1:0][SCW-1:0]   raw_cnt,
    input  logic [N_IN-1:0][SCW-1:0]   acc_cnt,
    output logic [N_IN-1:0]            en_o,
    output logic [N_IN-1:0][PS_W-1:0]  ps_o,
    output logic [N_IN-1:0]            ps_wr_o,
    output logic                       clr_o,
    output logic                       sw_trig_o,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid
);
    localparam int NWORDS = (N_IN + 31) / 32;

    logic [1:0]             bank;
    logic [7:0]             idx;
    logic                   wr_ctrl;
    logic [NWORDS*32-1:0]   mask_pad;
    logic [DATA_W-1:0]      rd_word;
    bus_state_t             state_q, state_d;

    assign bank     = bus_addr[ADDR_W-1:8];
    assign idx      = bus_addr[7:0];
    assign wr_ctrl  = bus_wr && (bank == BANK_CTRL);
    assign clr_o    = wr_ctrl && (idx == IDX_CLR);
    assign mask_pad = (NWORDS*32)'(en_o);

    for (genvar g = 0; g < N_IN; g++) begin : g_pswr
        assign ps_wr_o[g] = bus_wr && (bank == BANK_PS) && (idx == 8'(g));
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= '0;
            ps_o      <= '0;
            sw_trig_o <= 1'b0;
        end else begin
            sw_trig_o <= wr_ctrl && (idx == IDX_SW);
            for (int i = 0; i < N_IN; i++) begin
                if (wr_ctrl && (idx == 8'(i / 32))) en_o[i] <= bus_wdata[i % 32];
                if (ps_wr_o[i]) ps_o[i] <= bus_wdata[PS_W-1:0];
            end
        end
    end

    // read word select
    always_comb begin
        rd_word = '0;
        unique case (bank)
            BANK_CTRL: begin
                for (int w = 0; w < NWORDS; w++)
                    if (idx == 8'(w)) rd_word = mask_pad[w*32 +: 32];
            end
            BANK_PS: begin
                for (int i = 0; i < N_IN; i++)
                    if (idx == 8'(i)) rd_word = DATA_W'(ps_o[i]);
            end
            BANK_RAW: begin
                for (int i = 0; i < N_IN; i++)
                    if (idx == 8'(i)) rd_word = DATA_W'(raw_cnt[i]);
            end
            BANK_ACC: begin
                for (int i = 0; i < N_IN; i++)
                    if (idx == 8'(i)) rd_word = DATA_W'(acc_cnt[i]);
            end
        endcase
    end

    // read state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // read transitions: IDLE_TO_RESP, RESP_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_rd) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    // read outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            unique case (state_q)
                BUS_IDLE: bus_rdata <= bus_rd ? rd_word : '0;
                BUS_RESP: bus_rdata <= '0;
            endcase
        end
    end

    assign bus_rvalid = (state_q == BUS_RESP);

    AST_SW_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig_o |-> ($past(bus_wr) && $past(bus_addr) == {BANK_CTRL, IDX_SW}));  // R9
    AST_RVALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);                                               // R10
    AST_RVALID_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));                                             // R10
endmodule

// File: rtl/trig_input_cond.sv
module trig_input_cond
    import tic_pkg::*;
#(
    parameter int N_IN = 75,
    parameter int PS_W = 8,
    parameter int SCW  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_IN-1:0]     trig_i,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [N_IN-1:0]     trig_o,
    output logic                sw_trig_o
);
    logic [N_IN-1:0]            en;
    logic [N_IN-1:0][PS_W-1:0]  ps;
    logic [N_IN-1:0]            ps_wr;
    logic                       clr;
    logic [N_IN-1:0][SCW-1:0]   raw_cnt;
    logic [N_IN-1:0][SCW-1:0]   acc_cnt;

    tic_regs #(.N_IN(N_IN), .PS_W(PS_W), .SCW(SCW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .raw_cnt    (raw_cnt),
        .acc_cnt    (acc_cnt),
        .en_o       (en),
        .ps_o       (ps),
        .ps_wr_o    (ps_wr),
        .clr_o      (clr),
        .sw_trig_o  (sw_trig_o),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_chan
        tic_chan #(.PS_W(PS_W), .SCW(SCW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse   (trig_i[g]),
            .en      (en[g]),
            .ps      (ps[g]),
            .ps_wr   (ps_wr[g]),
            .clr     (clr),
            .acc_o   (trig_o[g]),
            .raw_cnt (raw_cnt[g]),
            .acc_cnt (acc_cnt[g])
        );
    end
endmodule

// File: tb/test_trig_input_cond.sv
module test_trig_input_cond;
    localparam int CLK_PERIOD = 4;
    localparam int N   = 75;
    localparam int SCW = 8;
    localparam logic [9:0] A_SW  = 10'h040;
    localparam logic [9:0] A_CLR = 10'h041;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  trig_i = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [N-1:0]  trig_o;
    logic          sw_trig_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_input_cond #(.N_IN(N), .PS_W(8), .SCW(SCW)) i_trig_input_cond (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .trig_o(trig_o), .sw_trig_o(sw_trig_o)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
        chk("R10 rvalid", bus_rvalid, 1'b1);
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] v, output logic [N-1:0] o);
        @(negedge clk); trig_i = v;
        @(negedge clk); o = trig_o; trig_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 trig_o", trig_o, '0);
        chk("R1 sw_trig_o", sw_trig_o, 1'b0);
        chk("R1 rvalid", bus_rvalid, 1'b0);
        rd(10'h000, d); chk("R1 enable word", d, 32'h0);
        rd(10'h105, d); chk("R1 prescale", d, 32'h0);
        rd(10'h205, d); chk("R1 raw scaler", d, 32'h0);
    endtask

    task automatic t_masked;
        logic [N-1:0] o;
        logic [31:0] d;
        pulse(N'(1) << 5, o); chk("R2 disabled line silent", o, '0);
        rd(10'h205, d); chk("R5 raw counts disabled pulse", d, 32'd1);
        rd(10'h305, d); chk("R5 accepted stays zero", d, 32'd0);
    endtask

    task automatic t_pass;
        logic [N-1:0] o, v;
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h001, 32'hFFFF_FFFF);
        wr(10'h002, 32'h0000_07FF);
        v = (N'(1) << 3) | (N'(1) << 33) | (N'(1) << 74);
        pulse(v, o); chk("R3 multi-line forward", o, v);
        @(negedge clk); chk("R3 single cycle", trig_o, '0);
        wr(10'h000, 32'hFFFF_FFF7);
        pulse((N'(1) << 3) | (N'(1) << 4), o);
        chk("R2 masked bit 3 of word 0", o, N'(1) << 4);
    endtask

    task automatic t_prescale;
        logic [N-1:0] o;
        logic [31:0] d;
        wr(10'h128, 32'd2);
        for (int k = 1; k <= 9; k++) begin
            pulse(N'(1) << 40, o);
            chk("R4 divide by 3", o[40], (k % 3) == 0);
        end
        pulse(N'(1) << 40, o); chk("R4 count 1", o[40], 1'b0);
        pulse(N'(1) << 40, o); chk("R4 count 2", o[40], 1'b0);
        wr(10'h001, 32'hFFFF_FEFF);
        pulse(N'(1) << 40, o); chk("R4 disabled no output", o[40], 1'b0);
        wr(10'h001, 32'hFFFF_FFFF);
        pulse(N'(1) << 40, o); chk("R4 disabled pulse did not advance", o[40], 1'b1);
        rd(10'h228, d); chk("R5 raw count line 40", d, 32'd13);
        rd(10'h328, d); chk("R5 accepted count line 40", d, 32'd4);
    endtask

    task automatic t_restart;
        logic [N-1:0] o;
        wr(10'h129, 32'd3);
        pulse(N'(1) << 41, o); pulse(N'(1) << 41, o);
        wr(10'h129, 32'd3);
        for (int k = 1; k <= 4; k++) begin
            pulse(N'(1) << 41, o);
            chk("R8 count restarted", o[41], k == 4);
        end
    endtask

    task automatic t_clear_coincident;
        logic [31:0] d;
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_CLR; trig_i = N'(1) << 4;
        @(negedge clk); bus_wr = 1'b0; trig_i = '0;
        chk("R7 coincident pulse forwarded", trig_o[4], 1'b1);
        rd(10'h204, d); chk("R7 coincident pulse not counted", d, 32'd0);
        rd(10'h228, d); chk("R7 other line cleared", d, 32'd0);
    endtask

    task automatic t_saturate;
        logic [31:0] d;
        @(negedge clk); trig_i = N'(1) << 7;
        repeat (260) @(negedge clk);
        trig_i = '0;
        rd(10'h207, d); chk("R6 raw saturates", d, 32'd255);
        rd(10'h307, d); chk("R6 accepted saturates", d, 32'd255);
        wr(A_CLR, 32'd0);
        rd(10'h207, d); chk("R7 clear releases saturation", d, 32'd0);
    endtask

    task automatic t_sw;
        logic [31:0] d;
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_SW; bus_wdata = 32'h0;
        @(negedge clk); bus_wr = 1'b0;
        chk("R9 sw pulse high", sw_trig_o, 1'b1);
        @(negedge clk); chk("R9 sw pulse one cycle", sw_trig_o, 1'b0);
        rd(A_SW, d);
        chk("R9 read does not fire", sw_trig_o, 1'b0);
        chk("R10 command address reads zero", d, 32'd0);
    endtask

    task automatic t_read;
        logic [31:0] d;
        rd(10'h0FF, d); chk("R10 unmapped reads zero", d, 32'd0);
        @(negedge clk); chk("R10 rvalid drops", bus_rvalid, 1'b0);
        rd(10'h002, d); chk("R10 enable word 2", d, 32'h0000_07FF);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 10'h128;
        @(negedge clk);
        chk("R10 first response valid", bus_rvalid, 1'b1);
        chk("R10 prescale readback", bus_rdata, 32'd2);
        bus_addr = 10'h129;
        @(negedge clk); chk("R10 request in response ignored", bus_rvalid, 1'b0);
        @(negedge clk); bus_rd = 1'b0;
        chk("R10 second response valid", bus_rvalid, 1'b1);
        chk("R10 second response data", bus_rdata, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_masked;
        t_pass;
        t_prescale;
        t_restart;
        t_clear_coincident;
        t_saturate;
        t_sw;
        t_read;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule